// File: doc/BRIEF.md
# Guard-Round-Sticky Mantissa Rounder

This block rounds an unpacked floating-point mantissa that still carries two extra low-order bits below its least significant bit. The upper of these two is the guard bit and the lower is the round bit. A separate sticky input records whether any nonzero bits were discarded further down. The block drops the two extra bits and, depending on the rounding mode and the sign, adds one at the new least significant bit. It reports whether that increment took place and whether the value was inexact.

A second, independent output tells a packing stage how an overflowing result of the given sign must saturate. It is either infinity or the largest finite magnitude, chosen by the rounding mode. The block is purely combinational. It does not adjust the exponent and does not renormalise a mantissa that has carried up to 2.0. The caller sees that case through the rounded-up output and the extra top bit of the result, and handles it.

Top module: `rnd_unit`

## Requirements
- R1: When no increment is made, `mant_o` equals `mant_i` shifted right by two, with zero in its top bit. The sticky input is not merged into the shifted value.
- R2: When `mant_i[1]`, `mant_i[0]` and `sticky_i` are all zero, `up_o` is 0 and `inexact_o` is 0 in every mode.
- R3: `inexact_o` is 1 whenever any of `mant_i[1]` (guard), `mant_i[0]` (round) or `sticky_i` is 1, in every mode.
- R4: In mode 0 (nearest, ties to even), `up_o` is 1 exactly when the guard bit is 1 and at least one of the round bit, `sticky_i` or `mant_i[2]` (the LSB after the shift) is 1.
- R5: In mode 1 (toward zero), `up_o` is always 0.
- R6: In mode 2 (toward plus infinity), `up_o` is 1 exactly when the value is inexact and `sign_i` is 0. In mode 3 (toward minus infinity), `up_o` is 1 exactly when the value is inexact and `sign_i` is 1.
- R7: When `up_o` is 1, `mant_o` equals the shifted mantissa plus one, with the carry running through every bit. An all-ones shifted mantissa becomes a 1 in the top bit of `mant_o` with zeros below (the 2.0 case), and the block leaves it uncorrected.
- R8: `ovf_inf_o` is 1 in mode 0 and 0 in mode 1. In mode 2 it equals the inverse of `sign_i`, and in mode 3 it equals `sign_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mant_i | input | W | Unrounded mantissa. Bit 1 is the guard bit and bit 0 is the round bit. |
| sticky_i | input | 1 | OR of all bits discarded below the round bit |
| sign_i | input | 1 | Sign of the value, 1 = negative |
| mode_i | input | 2 | Rounding mode: 0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf |
| mant_o | output | W-1 | Shifted and possibly incremented mantissa. The top bit catches the carry. |
| up_o | output | 1 | An increment was applied |
| inexact_o | output | 1 | Guard, round or sticky was nonzero |
| ovf_inf_o | output | 1 | An overflow of this sign goes to infinity (1) or to the largest finite magnitude (0) |

## Verification
The assertions assume that the four inputs are settled, two-state values when they are evaluated. They make no assumption about how the mantissa was normalised, so every bit pattern is legal, including an all-ones mantissa and an all-zero one.

The stimulus drives only defined values, and it waits after each change before it samples. It mixes uniformly random mantissas over all four modes and both signs with directed patterns. These patterns cover:
- exact inputs;
- ties that land on even and on odd LSBs;
- the carry into the top bit.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_POS     = 2'd2,
        RM_NEG     = 2'd3
    } rnd_mode_e;

    typedef struct packed {
        logic up;
        logic inexact;
    } rnd_dec_t;

endpackage

// File: rtl/rnd_split.sv
module rnd_split #(
    parameter int W = 64
) (
    input  logic [W-1:0] mant_i,
    output logic [W-3:0] base_o,
    output logic         grd_o,
    output logic         rbit_o,
    output logic         lsb_o
);
    localparam int NB = W - 2;

    always_comb begin
        base_o = mant_i[W-1:2];
        grd_o  = mant_i[1];
        rbit_o = mant_i[0];
        lsb_o  = mant_i[2];
    end

    logic [NB-1:0] unused_chk;
    assign unused_chk = base_o;
endmodule

// File: rtl/rnd_decide.sv
module rnd_decide
    import rnd_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       sign_i,
    input  logic       grd_i,
    input  logic       rbit_i,
    input  logic       sticky_i,
    input  logic       lsb_i,
    output logic       up_o,
    output logic       inexact_o
);
    rnd_dec_t dec_d;

    always_comb begin
        dec_d         = '0;
        dec_d.inexact = grd_i | rbit_i | sticky_i;
        if (dec_d.inexact) begin
            case (rnd_mode_e'(mode_i))
                RM_ZERO: dec_d.up = 1'b0;
                RM_POS:  dec_d.up = ~sign_i;
                RM_NEG:  dec_d.up = sign_i;
                default: dec_d.up = grd_i & (rbit_i | sticky_i | lsb_i);
            endcase
        end
    end

    assign up_o      = dec_d.up;
    assign inexact_o = dec_d.inexact;
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
    parameter int N = 62
) (
    input  logic [N-1:0] a_i,
    input  logic         inc_i,
    output logic [N:0]   sum_o
);
    logic [N:0] carry;

    assign carry[0] = inc_i;

    for (genvar k = 0; k < N; k++) begin : g_bit
        assign sum_o[k]   = a_i[k] ^ carry[k];
        assign carry[k+1] = a_i[k] & carry[k];
    end

    assign sum_o[N] = carry[N];
endmodule

// File: rtl/rnd_ovf.sv
module rnd_ovf
    import rnd_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       sign_i,
    output logic       to_inf_o
);
    always_comb begin
        case (rnd_mode_e'(mode_i))
            RM_ZERO: to_inf_o = 1'b0;
            RM_POS:  to_inf_o = ~sign_i;
            RM_NEG:  to_inf_o = sign_i;
            default: to_inf_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/rnd_unit.sv
module rnd_unit #(
    parameter int W = 64
) (
    input  logic [W-1:0] mant_i,
    input  logic         sticky_i,
    input  logic         sign_i,
    input  logic [1:0]   mode_i,
    output logic [W-2:0] mant_o,
    output logic         up_o,
    output logic         inexact_o,
    output logic         ovf_inf_o
);
    localparam int NB = W - 2;

    logic [NB-1:0] base;
    logic          grd;
    logic          rbit;
    logic          lsb;
    logic          up;

    rnd_split #(.W(W)) u_split (
        .mant_i (mant_i),
        .base_o (base),
        .grd_o  (grd),
        .rbit_o (rbit),
        .lsb_o  (lsb)
    );

    rnd_decide u_decide (
        .mode_i    (mode_i),
        .sign_i    (sign_i),
        .grd_i     (grd),
        .rbit_i    (rbit),
        .sticky_i  (sticky_i),
        .lsb_i     (lsb),
        .up_o      (up),
        .inexact_o (inexact_o)
    );

    rnd_incr #(.N(NB)) u_incr (
        .a_i   (base),
        .inc_i (up),
        .sum_o (mant_o)
    );

    rnd_ovf u_ovf (
        .mode_i   (mode_i),
        .sign_i   (sign_i),
        .to_inf_o (ovf_inf_o)
    );

    assign up_o = up;
endmodule

// File: rtl/rnd_unit_chk.sv
module rnd_unit_chk #(
    parameter int W = 64
) (
    input logic [W-1:0] mant_i,
    input logic         sticky_i,
    input logic         sign_i,
    input logic [1:0]   mode_i,
    input logic [W-2:0] mant_o,
    input logic         up_o,
    input logic         inexact_o,
    input logic         ovf_inf_o
);
    logic [W-2:0] shifted;
    assign shifted = {2'b00, mant_i[W-1:2]} >> 1;

    always_comb begin
        if (!up_o) begin
            assert_plain_shift_R1: assert (mant_o == {1'b0, mant_i[W-1:2]})
                else $error("R1 shift mismatch");
        end
        if (up_o) begin
            assert_up_needs_inexact_R2: assert (inexact_o)
                else $error("R2 increment on exact input");
            assert_incr_R7: assert (mant_o - {1'b0, mant_i[W-1:2]} == {{(W-2){1'b0}}, 1'b1})
                else $error("R7 increment mismatch");
        end
        if (mant_i[1] || mant_i[0] || sticky_i) begin
            assert_inexact_R3: assert (inexact_o) else $error("R3 inexact clear");
        end
        if (mode_i == 2'd0 && up_o) begin
            assert_nearest_guard_R4: assert (mant_i[1]) else $error("R4 up without guard");
        end
        if (mode_i == 2'd1) begin
            assert_zero_no_up_R5: assert (!up_o) else $error("R5 up toward zero");
            assert_zero_finite_R8: assert (!ovf_inf_o) else $error("R8 toward zero to inf");
        end
        if (mode_i == 2'd2 && sign_i) begin
            assert_pos_neg_down_R6: assert (!up_o) else $error("R6 up on negative");
        end
        if (mode_i == 2'd3 && !sign_i) begin
            assert_neg_pos_down_R6: assert (!up_o) else $error("R6 up on positive");
        end
        if (mode_i == 2'd0) begin
            assert_nearest_inf_R8: assert (ovf_inf_o) else $error("R8 nearest finite");
        end
    end

    logic unused_bits;
    assign unused_bits = ^shifted;
endmodule

bind rnd_unit rnd_unit_chk #(.W(W)) u_chk (
    .mant_i    (mant_i),
    .sticky_i  (sticky_i),
    .sign_i    (sign_i),
    .mode_i    (mode_i),
    .mant_o    (mant_o),
    .up_o      (up_o),
    .inexact_o (inexact_o),
    .ovf_inf_o (ovf_inf_o)
);

// File: tb/rnd_unit_tb.sv
module rnd_unit_tb;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic [W-1:0] mant_i = '0;
    logic         sticky_i = 1'b0;
    logic         sign_i = 1'b0;
    logic [1:0]   mode_i = 2'd0;
    logic [W-2:0] mant_o;
    logic         up_o;
    logic         inexact_o;
    logic         ovf_inf_o;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    rnd_unit #(.W(W)) u_dut (
        .mant_i    (mant_i),
        .sticky_i  (sticky_i),
        .sign_i    (sign_i),
        .mode_i    (mode_i),
        .mant_o    (mant_o),
        .up_o      (up_o),
        .inexact_o (inexact_o),
        .ovf_inf_o (ovf_inf_o)
    );

    function automatic logic exp_up(logic [W-1:0] m, logic s, logic sg, logic [1:0] md);
        logic g = m[1];
        logic r = m[0];
        if (!(g | r | s)) return 1'b0;
        case (md)
            2'd1: return 1'b0;
            2'd2: return !sg;
            2'd3: return sg;
            default: return g & (r | s | m[2]);
        endcase
    endfunction

    function automatic logic exp_inf(logic sg, logic [1:0] md);
        case (md)
            2'd1: return 1'b0;
            2'd2: return !sg;
            2'd3: return sg;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(string tag, logic [W-2:0] act, logic [W-2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (mant %h st %0b sg %0b md %0d)",
                     tag, act, exp, mant_i, sticky_i, sign_i, mode_i);
        end
    endtask

    task automatic apply(logic [W-1:0] m, logic s, logic sg, logic [1:0] md);
        logic e_up;
        logic e_nx;
        logic [W-2:0] e_m;
        @(negedge clk);
        mant_i = m; sticky_i = s; sign_i = sg; mode_i = md;
        #1;
        e_nx = m[1] | m[0] | s;
        e_up = exp_up(m, s, sg, md);
        e_m  = {1'b0, m[W-1:2]} + {{(W-2){1'b0}}, e_up};
        check(e_up ? "R7 mant" : "R1 mant", mant_o, e_m);
        check(e_nx ? "R3 inexact" : "R2 inexact", {{(W-2){1'b0}}, inexact_o}, {{(W-2){1'b0}}, e_nx});
        case (md)
            2'd0: check("R4 up", {{(W-2){1'b0}}, up_o}, {{(W-2){1'b0}}, e_up});
            2'd1: check("R5 up", {{(W-2){1'b0}}, up_o}, {{(W-2){1'b0}}, e_up});
            default: check("R6 up", {{(W-2){1'b0}}, up_o}, {{(W-2){1'b0}}, e_up});
        endcase
        check("R8 ovf", {{(W-2){1'b0}}, ovf_inf_o}, {{(W-2){1'b0}}, exp_inf(sg, md)});
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5eed_1234));
        // reset-state (all-zero inputs): exact, nearest
        apply('0, 1'b0, 1'b0, 2'd0);
        for (int md = 0; md < 4; md++) begin
            for (int sg = 0; sg < 2; sg++) begin
                // R2 exact in every mode
                apply(64'h8000_0000_0000_0004, 1'b0, sg[0], md[1:0]);
                // R7 carry to 2.0 from all ones
                apply('1, 1'b0, sg[0], md[1:0]);
                // R4 tie, even LSB stays
                apply(64'hC000_0000_0000_0002, 1'b0, sg[0], md[1:0]);
                // R4 tie, odd LSB rounds up
                apply(64'hC000_0000_0000_0006, 1'b0, sg[0], md[1:0]);
                // sticky alone (R3), tie broken by sticky
                apply(64'hC000_0000_0000_0000, 1'b1, sg[0], md[1:0]);
                apply(64'hC000_0000_0000_0002, 1'b1, sg[0], md[1:0]);
                // round bit only
                apply(64'hC000_0000_0000_0001, 1'b0, sg[0], md[1:0]);
            end
        end
        for (int i = 0; i < 3000; i++) begin
            apply({$urandom, $urandom}, 1'($urandom), 1'($urandom), 2'($urandom));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule